// File: doc/BRIEF.md
# External Interrupt Sense Controller

This block watches eight external interrupt pins and turns each into an interrupt request according to a per-pin sense mode: low level, falling edge or rising edge. Software programs the modes through two sense-control registers. It enables pins through a mask register, and it clears captured edges by writing ones to a flag register. A global interrupt enable gates every request. A per-pin acknowledge from the interrupt dispatcher clears the flag of a pin whose vector was taken.

The four low-numbered pins capture edges with flops clocked by the pin itself. They therefore record an edge and raise the wake-up output while the main I/O clock is stopped. The four high-numbered pins pass through a two-flop synchronizer and see edges only while the I/O clock runs. A pin held low in level mode wakes the part only after a slow wake-up clock has sampled it low twice in a row.

The block takes the pin value as it appears on the pad, whatever the pin's direction. A pin that the chip drives itself can therefore raise its own interrupt.

Top module: `pin_irq_sense`

## Requirements
- R1: After reset all four registers read zero, so every pin is in low-level mode with its mask off. The outputs `irq_o` and `wake_o` are low.
- R2: Register addresses: 0 holds sense fields for pins 3..0, 1 holds those for pins 7..4, 2 is the mask (bit n is pin n), 3 is the flags (bit n is pin n). Pin n's field sits at bits [2(n mod 4)+1 : 2(n mod 4)] of its sense register. Written sense and mask values read back unchanged.
- R3: `irq_o[n]` can be high only while `gie_i` is high and mask bit n is set.
- R4: Sense code 00 (low level) makes the request follow the synchronized pin: it is high while the pin is low. This mode never sets the flag, and an acknowledge does not drop the request.
- R5: Pins 7..4 with code 10 (falling) or 11 (rising) set their flag on the third I/O clock rising edge after the pin changes. A pulse that comes and goes while the I/O clock is stopped is not seen. An edge of the opposite polarity sets nothing.
- R6: Pins 3..0 with an edge code set their flag as soon as the edge occurs, with the I/O clock stopped. The flag raises `irq_o[n]` and `wake_o` when gated on.
- R7: Writing address 3 clears every flag whose data bit is one. Bits written as zero leave their flags unchanged.
- R8: A one-cycle `ack_i[n]` clears pin n's edge flag.
- R9: In level mode a gated-on pin raises `wake_o` only after two consecutive `wk_clk` rising edges have sampled it low. It drops one `wk_clk` edge after the pin returns high.
- R10: A sense-field write that makes the decoded edge condition go from false to true sets that pin's flag, even while its mask bit is off.
- R11: Sense code 01 disables the pin: no request, no flag and no wake, whatever the pin does.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Main I/O clock; may be stopped |
| wk_clk | input | 1 | Slow free-running wake-up sampling clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| addr | input | 2 | Register address |
| wr_data | input | 8 | Register write data |
| rd_data | output | 8 | Register read data for `addr` |
| pin_i | input | 8 | Raw interrupt pin levels |
| gie_i | input | 1 | Global interrupt enable |
| ack_i | input | 8 | Per-pin interrupt-taken pulse |
| irq_o | output | 8 | Per-pin interrupt requests |
| wake_o | output | 1 | Wake-up request |

## Verification
The assertions check four rules on every cycle:
- Requests stay inside the global enable and the mask.
- Wake-up never appears without the global enable.
- A flag that was told to clear, with no concurrent set event, is low on the next I/O clock edge.
- The level filter reports a pin low only when the two preceding `wk_clk` samples of the pin were both low.

Only the bench scenarios can show the rest. These are the three-edge latency of the synchronized pins and the blindness of those pins to pulses while the clock is stopped. They also cover edge capture on the low pins with the clock halted, the flag set by rewriting a sense field, and the disabled code.

// File: rtl/pin_irq_pkg.sv
package pin_irq_pkg;

  typedef enum logic [1:0] {
    SENSE_LOW  = 2'b00,
    SENSE_OFF  = 2'b01,
    SENSE_FALL = 2'b10,
    SENSE_RISE = 2'b11
  } sense_e;

  localparam logic [1:0] ADDR_SENSE_LO = 2'd0;
  localparam logic [1:0] ADDR_SENSE_HI = 2'd1;
  localparam logic [1:0] ADDR_MASK     = 2'd2;
  localparam logic [1:0] ADDR_FLAG     = 2'd3;

  // Decoded condition: true when the pin sits on the "active" side for the mode.
  function automatic logic sense_cond(input sense_e mode, input logic pin);
    case (mode)
      SENSE_LOW:  sense_cond = ~pin;
      SENSE_FALL: sense_cond = ~pin;
      SENSE_RISE: sense_cond = pin;
      default:    sense_cond = 1'b0;
    endcase
  endfunction

  function automatic logic sense_is_edge(input sense_e mode);
    sense_is_edge = (mode == SENSE_FALL) || (mode == SENSE_RISE);
  endfunction

endpackage

// File: rtl/pin_irq_regs.sv
module pin_irq_regs
  import pin_irq_pkg::*;
#(
  parameter int NPINS = 8
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 wr_en,
  input  logic [1:0]           addr,
  input  logic [NPINS-1:0]     wr_data,
  input  logic [NPINS-1:0]     flag_rd,
  output logic [2*NPINS-1:0]   sense_o,
  output logic [NPINS-1:0]     mask_o,
  output logic [NPINS-1:0]     flag_clr_o,
  output logic [NPINS-1:0]     rd_data
);

  logic [NPINS-1:0] sense_lo_q;
  logic [NPINS-1:0] sense_hi_q;
  logic [NPINS-1:0] mask_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sense_lo_q <= '0;
      sense_hi_q <= '0;
      mask_q     <= '0;
    end else if (wr_en) begin
      case (addr)
        ADDR_SENSE_LO: sense_lo_q <= wr_data;
        ADDR_SENSE_HI: sense_hi_q <= wr_data;
        ADDR_MASK:     mask_q     <= wr_data;
        default:       ;
      endcase
    end
  end

  assign sense_o    = {sense_hi_q, sense_lo_q};
  assign mask_o     = mask_q;
  assign flag_clr_o = (wr_en && addr == ADDR_FLAG) ? wr_data : '0;

  always_comb begin
    case (addr)
      ADDR_SENSE_LO: rd_data = sense_lo_q;
      ADDR_SENSE_HI: rd_data = sense_hi_q;
      ADDR_MASK:     rd_data = mask_q;
      default:       rd_data = flag_rd;
    endcase
  end

endmodule

// File: rtl/level_wake_filter.sv
module level_wake_filter #(
  parameter int STAGES = 2
) (
  input  logic wk_clk,
  input  logic rst_n,
  input  logic pin_i,
  output logic low_ok
);

  logic [STAGES-1:0] low_sh;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge wk_clk or negedge rst_n) begin
        if (!rst_n) low_sh <= '0;
        else        low_sh <= ~pin_i;
      end
    end else begin : g_many
      always_ff @(posedge wk_clk or negedge rst_n) begin
        if (!rst_n) low_sh <= '0;
        else        low_sh <= {low_sh[STAGES-2:0], ~pin_i};
      end
    end
  endgenerate

  assign low_ok = &low_sh;

endmodule

// File: rtl/pin_sense_cell.sv
module pin_sense_cell
  import pin_irq_pkg::*;
#(
  parameter bit ASYNC_EDGE  = 1'b0,
  parameter int SYNC_STAGES = 2,
  parameter int WAKE_STAGES = 2
) (
  input  logic       clk,
  input  logic       wk_clk,
  input  logic       rst_n,
  input  logic       pin_i,
  input  logic [1:0] sense_i,
  input  logic       gate_i,
  input  logic       clr_i,
  output logic       irq_o,
  output logic       wake_o,
  output logic       flag_o,
  output logic       flag_r_o,
  output logic       set_o,
  output logic       lvl_ok_o
);

  sense_e mode;
  assign mode = sense_e'(sense_i);

  // Synchronizer for the I/O clock domain; pins idle high.
  logic [SYNC_STAGES-1:0] sync_sh;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_sh <= '1;
    else        sync_sh <= {sync_sh[SYNC_STAGES-2:0], pin_i};
  end

  logic pin_s;
  assign pin_s = sync_sh[SYNC_STAGES-1];

  logic cond, cond_q, cond_rise;
  assign cond = sense_cond(mode, pin_s);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cond_q <= 1'b0;
    else        cond_q <= cond;
  end

  assign cond_rise = sense_is_edge(mode) & cond & ~cond_q;

  logic set_evt;
  logic cap;

  generate
    if (ASYNC_EDGE) begin : g_async
      sense_e mode_q;
      logic   cap_clr_q;
      logic   rise_cap;
      logic   fall_cap;

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) mode_q <= SENSE_LOW;
        else        mode_q <= mode;
      end

      // Edges come from the pin flops; the clocked path only sees mode rewrites.
      assign set_evt = cond_rise & (mode != mode_q);

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cap_clr_q <= 1'b1;
        else        cap_clr_q <= clr_i;
      end

      always_ff @(posedge pin_i or posedge cap_clr_q) begin
        if (cap_clr_q)                rise_cap <= 1'b0;
        else if (mode == SENSE_RISE)  rise_cap <= 1'b1;
      end

      always_ff @(negedge pin_i or posedge cap_clr_q) begin
        if (cap_clr_q)                fall_cap <= 1'b0;
        else if (mode == SENSE_FALL)  fall_cap <= 1'b1;
      end

      assign cap = rise_cap | fall_cap;
    end else begin : g_sync
      assign set_evt = cond_rise;
      assign cap     = 1'b0;
    end
  endgenerate

  logic flag_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       flag_q <= 1'b0;
    else if (set_evt) flag_q <= 1'b1;
    else if (clr_i)   flag_q <= 1'b0;
  end

  logic lvl_ok;
  level_wake_filter #(.STAGES(WAKE_STAGES)) u_filt (
    .wk_clk (wk_clk),
    .rst_n  (rst_n),
    .pin_i  (pin_i),
    .low_ok (lvl_ok)
  );

  logic is_level, request;
  assign is_level = (mode == SENSE_LOW);
  assign flag_o   = flag_q | cap;
  assign request  = is_level ? cond : flag_o;

  assign irq_o    = gate_i & request;
  assign wake_o   = gate_i & ((is_level & lvl_ok) | cap);
  assign flag_r_o = flag_q;
  assign set_o    = set_evt;
  assign lvl_ok_o = lvl_ok;

endmodule

// File: rtl/pin_irq_sense.sv
module pin_irq_sense
  import pin_irq_pkg::*;
#(
  parameter int NPINS       = 8,
  parameter int NASYNC      = 4,
  parameter int SYNC_STAGES = 2,
  parameter int WAKE_STAGES = 2
) (
  input  logic             clk,
  input  logic             wk_clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [1:0]       addr,
  input  logic [NPINS-1:0] wr_data,
  output logic [NPINS-1:0] rd_data,
  input  logic [NPINS-1:0] pin_i,
  input  logic             gie_i,
  input  logic [NPINS-1:0] ack_i,
  output logic [NPINS-1:0] irq_o,
  output logic             wake_o
);

  logic [2*NPINS-1:0] sense_vec;
  logic [NPINS-1:0]   mask_q;
  logic [NPINS-1:0]   flag_clr;
  logic [NPINS-1:0]   flag_vec;
  logic [NPINS-1:0]   flag_r;
  logic [NPINS-1:0]   clr_vec;
  logic [NPINS-1:0]   set_evt;
  logic [NPINS-1:0]   lvl_ok;
  logic [NPINS-1:0]   wake_vec;

  pin_irq_regs #(.NPINS(NPINS)) u_regs (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_en      (wr_en),
    .addr       (addr),
    .wr_data    (wr_data),
    .flag_rd    (flag_vec),
    .sense_o    (sense_vec),
    .mask_o     (mask_q),
    .flag_clr_o (flag_clr),
    .rd_data    (rd_data)
  );

  assign clr_vec = flag_clr | ack_i;

  generate
    for (genvar i = 0; i < NPINS; i++) begin : g_pin
      pin_sense_cell #(
        .ASYNC_EDGE  (i < NASYNC),
        .SYNC_STAGES (SYNC_STAGES),
        .WAKE_STAGES (WAKE_STAGES)
      ) u_cell (
        .clk      (clk),
        .wk_clk   (wk_clk),
        .rst_n    (rst_n),
        .pin_i    (pin_i[i]),
        .sense_i  (sense_vec[2*i +: 2]),
        .gate_i   (gie_i & mask_q[i]),
        .clr_i    (clr_vec[i]),
        .irq_o    (irq_o[i]),
        .wake_o   (wake_vec[i]),
        .flag_o   (flag_vec[i]),
        .flag_r_o (flag_r[i]),
        .set_o    (set_evt[i]),
        .lvl_ok_o (lvl_ok[i])
      );
    end
  endgenerate

  assign wake_o = |wake_vec;

endmodule

// File: rtl/pin_irq_sense_chk.sv
module pin_irq_sense_chk #(
  parameter int NPINS = 8
) (
  input logic             clk,
  input logic             wk_clk,
  input logic             rst_n,
  input logic             gie_i,
  input logic [NPINS-1:0] pin_i,
  input logic [NPINS-1:0] irq_o,
  input logic             wake_o,
  input logic [NPINS-1:0] mask_q,
  input logic [NPINS-1:0] flag_r,
  input logic [NPINS-1:0] clr_vec,
  input logic [NPINS-1:0] set_evt,
  input logic [NPINS-1:0] lvl_ok
);

  // R3
  irq_gie_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_o != '0) |-> gie_i);

  // R3
  irq_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_o & ~mask_q) == '0);

  // R7
  flag_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_r & $past(clr_vec & ~set_evt)) == '0);

  // R9
  lvl_filter_chk: assert property (@(posedge wk_clk) disable iff (!rst_n)
    (lvl_ok & ($past(pin_i) | $past(pin_i, 2))) == '0);

  // R6
  wake_gie_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wake_o |-> gie_i);

endmodule

bind pin_irq_sense pin_irq_sense_chk #(.NPINS(NPINS)) u_chk (
  .clk     (clk),
  .wk_clk  (wk_clk),
  .rst_n   (rst_n),
  .gie_i   (gie_i),
  .pin_i   (pin_i),
  .irq_o   (irq_o),
  .wake_o  (wake_o),
  .mask_q  (mask_q),
  .flag_r  (flag_r),
  .clr_vec (clr_vec),
  .set_evt (set_evt),
  .lvl_ok  (lvl_ok)
);

// File: tb/pin_irq_sense_bench.sv
module pin_irq_sense_bench;

  logic       clk = 1'b0;
  logic       clk_run = 1'b1;
  logic       wk_clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_en = 1'b0;
  logic [1:0] addr = 2'd0;
  logic [7:0] wr_data = 8'h00;
  logic [7:0] rd_data;
  logic [7:0] pin = 8'hFF;
  logic       gie = 1'b1;
  logic [7:0] ack = 8'h00;
  logic [7:0] irq;
  logic       wake;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  // 50 MHz I/O clock that the bench can halt (always halted low).
  initial forever begin
    #10;
    if (clk_run) clk = ~clk;
  end

  initial forever #200 wk_clk = ~wk_clk;

  pin_irq_sense u_pin_irq_sense (
    .clk     (clk),
    .wk_clk  (wk_clk),
    .rst_n   (rst_n),
    .wr_en   (wr_en),
    .addr    (addr),
    .wr_data (wr_data),
    .rd_data (rd_data),
    .pin_i   (pin),
    .gie_i   (gie),
    .ack_i   (ack),
    .irq_o   (irq),
    .wake_o  (wake)
  );

  // Scoreboard: kind 0 = irq, 1 = wake, 2 = rd_data.
  string      tag_q[$];
  int         kind_q[$];
  logic [7:0] exp_q[$];
  event       chk_ev;

  initial forever begin
    @(chk_ev);
    while (kind_q.size() > 0) begin
      string      t;
      int         k;
      logic [7:0] e;
      logic [7:0] a;
      t = tag_q.pop_front();
      k = kind_q.pop_front();
      e = exp_q.pop_front();
      a = (k == 0) ? irq : (k == 1) ? {7'b0, wake} : rd_data;
      checks++;
      if (a !== e) begin
        errors++;
        $display("FAIL %s actual %h expected %h", t, a, e);
      end
    end
  end

  task automatic expect_item(input string t, input int k, input logic [7:0] e);
    tag_q.push_back(t);
    kind_q.push_back(k);
    exp_q.push_back(e);
    ->chk_ev;
    #1;
  endtask

  task automatic cycles(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic reg_write(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic read_expect(input logic [1:0] a, input logic [7:0] e, input string t);
    addr = a;
    #1;
    expect_item(t, 2, e);
  endtask

  task automatic stop_clk();
    @(negedge clk);
    clk_run = 1'b0;
  endtask

  task automatic start_clk();
    clk_run = 1'b1;
    @(negedge clk);
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual running expected finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    cycles(5);
    rst_n = 1'b1;
    cycles(2);

    // R1 reset state
    read_expect(2'd0, 8'h00, "R1 sense lo");
    read_expect(2'd1, 8'h00, "R1 sense hi");
    read_expect(2'd2, 8'h00, "R1 mask");
    read_expect(2'd3, 8'h00, "R1 flags");
    expect_item("R1 irq", 0, 8'h00);
    expect_item("R1 wake", 1, 8'h00);

    // R4 level mode on pin 5
    reg_write(2'd2, 8'h20);
    pin[5] = 1'b0;
    cycles(3);
    expect_item("R4 level request", 0, 8'h20);
    gie = 1'b0; #1;
    expect_item("R3 gie off", 0, 8'h00);
    gie = 1'b1; #1;
    @(negedge clk); ack[5] = 1'b1;
    @(negedge clk); ack[5] = 1'b0;
    expect_item("R4 ack ignored", 0, 8'h20);
    read_expect(2'd3, 8'h00, "R4 no flag");
    pin[5] = 1'b1;
    cycles(3);
    expect_item("R4 level released", 0, 8'h00);

    // R9 level wake filter
    @(posedge wk_clk); @(posedge wk_clk); #5;
    pin[5] = 1'b0;
    @(posedge wk_clk); #1;
    expect_item("R9 one sample", 1, 8'h00);
    @(posedge wk_clk); #1;
    expect_item("R9 two samples", 1, 8'h01);
    pin[5] = 1'b1;
    @(posedge wk_clk); #1;
    expect_item("R9 released", 1, 8'h00);
    cycles(3);

    // R10 sense rewrite sets flag with mask off (pin 1 high, low -> rising)
    reg_write(2'd2, 8'h00);
    reg_write(2'd0, 8'h0C);
    cycles(2);
    read_expect(2'd3, 8'h02, "R10 flag from rewrite");
    expect_item("R10 masked irq", 0, 8'h00);
    reg_write(2'd3, 8'h02);
    cycles(1);
    read_expect(2'd3, 8'h00, "R7 flag cleared");
    reg_write(2'd0, 8'h00);

    // R5 upper pin 6 falling
    reg_write(2'd1, 8'h20);
    reg_write(2'd2, 8'h40);
    cycles(2);
    expect_item("R5 no spurious", 0, 8'h00);
    @(negedge clk); pin[6] = 1'b0;
    cycles(2);
    expect_item("R5 before third edge", 0, 8'h00);
    cycles(1);
    expect_item("R5 third edge", 0, 8'h40);
    reg_write(2'd3, 8'h00);
    expect_item("R7 zero write", 0, 8'h40);
    reg_write(2'd3, 8'hBF);
    expect_item("R7 other bits", 0, 8'h40);
    reg_write(2'd3, 8'h40);
    expect_item("R7 one write", 0, 8'h00);
    pin[6] = 1'b1;
    cycles(4);
    expect_item("R5 opposite edge", 0, 8'h00);

    // R8 acknowledge
    pin[6] = 1'b0;
    cycles(4);
    expect_item("R8 flag set", 0, 8'h40);
    @(negedge clk); ack[6] = 1'b1;
    @(negedge clk); ack[6] = 1'b0;
    expect_item("R8 ack clears", 0, 8'h00);
    pin[6] = 1'b1;
    cycles(3);

    // R5 pulse while clock halted on upper pin
    stop_clk();
    #50 pin[6] = 1'b0;
    #50 pin[6] = 1'b1;
    #50;
    start_clk();
    cycles(4);
    expect_item("R5 halted pulse", 0, 8'h00);
    read_expect(2'd3, 8'h00, "R5 halted no flag");

    // R6 lower pin 2 rising with clock halted
    pin[2] = 1'b0;
    cycles(3);
    reg_write(2'd0, 8'h30);
    reg_write(2'd2, 8'h04);
    cycles(2);
    read_expect(2'd3, 8'h00, "R6 no flag before edge");
    stop_clk();
    #15 pin[2] = 1'b1;
    #30;
    expect_item("R6 async irq", 0, 8'h04);
    expect_item("R6 async wake", 1, 8'h01);
    start_clk();
    cycles(2);
    expect_item("R6 held after restart", 0, 8'h04);
    reg_write(2'd3, 8'h04);
    cycles(1);
    expect_item("R7 lower cleared irq", 0, 8'h00);
    expect_item("R7 lower cleared wake", 1, 8'h00);

    // R6 / R8 lower pin 3 falling, acknowledged
    reg_write(2'd0, 8'hB0);
    reg_write(2'd2, 8'h08);
    cycles(2);
    stop_clk();
    #15 pin[3] = 1'b0;
    #30;
    expect_item("R6 async falling irq", 0, 8'h08);
    expect_item("R6 async falling wake", 1, 8'h01);
    start_clk();
    @(negedge clk); ack[3] = 1'b1;
    @(negedge clk); ack[3] = 1'b0;
    cycles(1);
    expect_item("R8 lower ack irq", 0, 8'h00);
    expect_item("R8 lower ack wake", 1, 8'h00);

    // R11 disabled code on pin 4
    reg_write(2'd1, 8'h21);
    reg_write(2'd2, 8'h10);
    pin[4] = 1'b0;
    cycles(4);
    expect_item("R11 no request", 0, 8'h00);
    read_expect(2'd3, 8'h00, "R11 no flag");
    @(posedge wk_clk); @(posedge wk_clk); #1;
    expect_item("R11 no wake", 1, 8'h00);
    pin[4] = 1'b1;
    cycles(4);
    expect_item("R11 released", 0, 8'h00);

    // R2 read back
    read_expect(2'd0, 8'hB0, "R2 sense lo");
    read_expect(2'd1, 8'h21, "R2 sense hi");
    read_expect(2'd2, 8'h10, "R2 mask");

    #100;
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule